// File: doc/BRIEF.md
# PCM Serial Audio Output Formatter

This block turns a stream of stereo sample pairs into a three-wire serial audio link for an external DAC. It runs on the oversampling master clock and derives two clocks from it: a bit clock, and a word clock whose level marks the left or right slot. It then drives one serial data line. Each frame lasts exactly one sample period, which is 256, 384 or 512 master clock cycles. Each frame has two slots of 16 or 32 bit clocks.

Before a pair is sent, the block applies channel routing. The four modes are stereo, left on both outputs, right on both outputs, and swapped. It then scales each output channel by its own attenuation setting in 1 dB steps. Last, it places the word into its slot. In the wide slot the data word can be 16, 18, 20 or 24 bits, packed against either end of the slot. Each slot can be sent MSB first or LSB first. Pairs enter over a valid/ready handshake that is offered once per frame. If no pair is offered, the last pair is sent again and an underrun flag is raised. A mute input zeroes the data line while both clocks keep running.

All configuration inputs except mute are sampled at each frame boundary. A frame therefore never mixes two settings.

Top module: `pcm_out_fmt`

## Requirements
- R1: A frame lasts 256, 384 or 512 master clock cycles for `osr_i` = 0, 1 or 2 (3 acts as 0). It holds 64 bit clock periods when `slot32_i`=1 and 32 when it is 0. Each bit period is half low and half high, and it starts with the bit clock low.
- R2: `ws_o` is low for the left slot and high for the right slot. `ws_o` and `sdo_o` change only on the cycle in which `bclk_o` falls. Right after a frame boundary `bclk_o` and `ws_o` are both low.
- R3: With `lsb_first_i`=0 each slot is sent starting from bit S-1, where S is the slot width. With `lsb_first_i`=1 each slot is sent starting from bit 0.
- R4: With `slot32_i`=0 each slot is 16 bits wide and carries bits 23..8 of the processed 24-bit sample. `dwidth_i` and `rjust_i` have no effect in this mode.
- R5: With `slot32_i`=1, `dwidth_i` 0/1/2/3 selects 16/18/20/24 data bits, taken from the top of the 24-bit sample. With `rjust_i`=0 the data fills slot bits 31 downward. With `rjust_i`=1 it fills slot bits from 0 upward. All other slot bits are zero.
- R6: `route_i` selects the routing. 0 sends left to left and right to right. 1 sends the left input to both outputs. 2 sends the right input to both outputs. 3 swaps the two channels.
- R7: Each output sample equals floor(x·g/32768), where x is the routed input and g = round(32768·10^(-n/20)). Here n is the channel's attenuation input, and values above 96 are treated as 96.
- R8: `ready_o` is high for one master clock cycle: the last cycle of each frame. A pair presented with `valid_i` high in that cycle is sent in the frame that starts at the next edge. Routing, attenuation and format are sampled in the same cycle.
- R9: If `valid_i` is low during the `ready_o` cycle, the previously accepted pair is sent again with the current settings. `underrun_o` then goes high for that frame. It goes low again in the first frame whose pair was accepted.
- R10: While `mute_i` is high, every bit placed on `sdo_o` is 0. The bit clock and word clock continue unchanged.
- R11: During reset `bclk_o`, `ws_o`, `sdo_o`, `ready_o` and `underrun_o` are low. The first frame after reset uses 32-bit slots and ratio 256, and its data is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample pair offered |
| ready_o | output | 1 | Pair taken this cycle (last cycle of frame) |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| slot32_i | input | 1 | 1: 32-bit slots, 0: 16-bit slots |
| osr_i | input | 2 | Master clock ratio: 0=256, 1=384, 2=512 |
| dwidth_i | input | 2 | Data bits in a 32-bit slot: 16/18/20/24 |
| rjust_i | input | 1 | 1: data at slot LSB end, 0: at MSB end |
| lsb_first_i | input | 1 | 1: send slot LSB first |
| route_i | input | 2 | Channel routing mode |
| att_l_i | input | ATT_W | Left output attenuation in dB |
| att_r_i | input | ATT_W | Right output attenuation in dB |
| mute_i | input | 1 | Force serial data to zero |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word clock, high during right slot |
| sdo_o | output | 1 | Serial data, changes on bit clock fall |
| underrun_o | output | 1 | Current frame repeats the previous pair |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 16-bit gain coefficients, 8-bit attenuation and a 96 dB floor. With these values the attenuation clamp above 96 and the smallest non-zero coefficient can both be reached. Every ratio, slot width, data width, justification, bit order and routing mode is a run-time input, so one build covers each combination frame by frame, including changes between consecutive frames. Frame length, the repeated pair during an underrun, and muted frames are all checked against values the bench computes on its own.

// File: rtl/pcm_fmt_pkg.sv
`timescale 1ns/1ps
package pcm_fmt_pkg;

  localparam int FMT_W  = 24;  // aligned sample width fed to slot logic
  localparam int SLOT_W = 32;  // widest slot
  localparam int NARROW = 16;  // narrow slot

  typedef enum logic [1:0] {
    ROUTE_STEREO = 2'd0,
    ROUTE_DUP_L  = 2'd1,
    ROUTE_DUP_R  = 2'd2,
    ROUTE_SWAP   = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    OSR_256 = 2'd0,
    OSR_384 = 2'd1,
    OSR_512 = 2'd2,
    OSR_ALT = 2'd3
  } osr_e;

  typedef struct packed {
    logic       slot32;
    logic [1:0] dwidth;
    logic       rjust;
    logic       lsb_first;
  } slot_cfg_t;

  // round(2^frac * 10^(-n/20)), evaluated at elaboration
  function automatic int unsigned gain_coef(int n, int frac);
    real r;
    r = (2.0 ** frac) * (10.0 ** ((0.0 - n) / 20.0));
    return $rtoi(r + 0.5);
  endfunction

endpackage

// File: rtl/pcm_fmt_timing.sv
`timescale 1ns/1ps
module pcm_fmt_timing #(
  parameter int TICK_W = 4,
  parameter int BIT_W  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slot32_i,
  input  logic [1:0] osr_i,
  output logic       bclk_o,
  output logic       ws_o,
  output logic       adv_o,
  output logic       load_o
);
  import pcm_fmt_pkg::*;

  logic [TICK_W-1:0] tick_q, half;
  logic              phase_q, ws_q;
  logic [BIT_W-1:0]  bit_q, nbit, last, slot_bits;
  logic              slot32_q;
  osr_e              osr_q;
  logic              tick_end;

  // half bit period in master cycles = ratio / (4 * slot bits)
  function automatic logic [TICK_W-1:0] half_f(logic s32, osr_e osr);
    logic [TICK_W-1:0] base;
    unique case (osr)
      OSR_384: base = TICK_W'(3);
      OSR_512: base = TICK_W'(4);
      default: base = TICK_W'(2);
    endcase
    return s32 ? base : (base << 1);
  endfunction

  always_comb begin
    half      = half_f(slot32_q, osr_q);
    tick_end  = (tick_q == half - TICK_W'(1));
    adv_o     = tick_end & phase_q;
    last      = slot32_q ? BIT_W'(2*SLOT_W-1) : BIT_W'(2*NARROW-1);
    slot_bits = slot32_q ? BIT_W'(SLOT_W) : BIT_W'(NARROW);
    load_o    = adv_o & (bit_q == last);
    nbit      = load_o ? '0 : bit_q + BIT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q   <= '0;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      ws_q     <= 1'b0;
      slot32_q <= 1'b1;
      osr_q    <= OSR_256;
    end else begin
      tick_q <= tick_end ? '0 : tick_q + TICK_W'(1);
      if (tick_end) phase_q <= ~phase_q;
      if (adv_o) begin
        bit_q <= nbit;
        ws_q  <= (nbit >= slot_bits);
      end
      if (load_o) begin
        slot32_q <= slot32_i;
        osr_q    <= osr_e'(osr_i);
      end
    end
  end

  assign bclk_o = phase_q;
  assign ws_o   = ws_q;

endmodule

// File: rtl/pcm_fmt_gain.sv
`timescale 1ns/1ps
module pcm_fmt_gain #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 16,
  parameter int ATT_W    = 8,
  parameter int MAX_ATT  = 96
) (
  input  logic [SAMPLE_W-1:0]      left_i,
  input  logic [SAMPLE_W-1:0]      right_i,
  input  logic [1:0]               route_i,
  input  logic [ATT_W-1:0]         att_l_i,
  input  logic [ATT_W-1:0]         att_r_i,
  output logic [1:0][SAMPLE_W-1:0] out_o
);
  import pcm_fmt_pkg::*;

  localparam int FRAC   = GAIN_W - 1;
  localparam int IDX_W  = $clog2(MAX_ATT + 1);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic [GAIN_W-1:0] gain_tbl [MAX_ATT+1];

  for (genvar g = 0; g <= MAX_ATT; g++) begin : g_tbl
    localparam int unsigned COEF = gain_coef(g, FRAC);
    assign gain_tbl[g] = GAIN_W'(COEF);
  end

  route_e route;
  assign route = route_e'(route_i);

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [SAMPLE_W-1:0]      src;
    logic [ATT_W-1:0]         att_raw;
    logic [IDX_W-1:0]         idx;
    logic signed [PROD_W-1:0] prod, scaled;

    always_comb begin
      if (ch == 0)
        src = (route == ROUTE_STEREO || route == ROUTE_DUP_L) ? left_i : right_i;
      else
        src = (route == ROUTE_STEREO || route == ROUTE_DUP_R) ? right_i : left_i;
      att_raw = (ch == 0) ? att_l_i : att_r_i;
      idx     = (att_raw > ATT_W'(MAX_ATT)) ? IDX_W'(MAX_ATT) : IDX_W'(att_raw);
      prod    = PROD_W'($signed(src)) * $signed({1'b0, gain_tbl[idx]});
      scaled  = prod >>> FRAC;
      out_o[ch] = scaled[SAMPLE_W-1:0];
    end
  end

endmodule

// File: rtl/pcm_fmt_slot.sv
`timescale 1ns/1ps
module pcm_fmt_slot #(
  parameter int SAMPLE_W = 24
) (
  input  logic [1:0][SAMPLE_W-1:0]          sample_i,
  input  pcm_fmt_pkg::slot_cfg_t            cfg_i,
  output logic [2*pcm_fmt_pkg::SLOT_W-1:0]  frame_o
);
  import pcm_fmt_pkg::*;

  function automatic logic [SLOT_W-1:0] slot_word(logic [FMT_W-1:0] s, slot_cfg_t c);
    int w;
    w = (c.dwidth == 2'd3) ? 24 : 16 + 2 * int'(c.dwidth);
    if (!c.slot32) return {16'h0, s[FMT_W-1 -: NARROW]};
    if (c.rjust)   return {8'h0, s} >> (FMT_W - w);
    return {s, 8'h0} & ~(32'hFFFF_FFFF >> w);
  endfunction

  // bit k of the result is the k-th bit on the line
  function automatic logic [SLOT_W-1:0] tx_order(logic [SLOT_W-1:0] v, slot_cfg_t c);
    logic [SLOT_W-1:0] t;
    t = '0;
    for (int k = 0; k < SLOT_W; k++) begin
      if (c.lsb_first)   t[k] = v[k];
      else if (c.slot32) t[k] = v[SLOT_W-1-k];
      else if (k < NARROW) t[k] = v[NARROW-1-k];
    end
    return t;
  endfunction

  logic [1:0][SLOT_W-1:0] tx;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [FMT_W-1:0] top_bits;
    assign top_bits = sample_i[ch][SAMPLE_W-1 -: FMT_W];
    assign tx[ch]   = tx_order(slot_word(top_bits, cfg_i), cfg_i);
  end

  assign frame_o = cfg_i.slot32 ? {tx[1], tx[0]}
                                : {32'h0, tx[1][NARROW-1:0], tx[0][NARROW-1:0]};

endmodule

// File: rtl/pcm_out_fmt.sv
`timescale 1ns/1ps
module pcm_out_fmt #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 16,
  parameter int ATT_W    = 8,
  parameter int MAX_ATT  = 96,
  parameter int TICK_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                slot32_i,
  input  logic [1:0]          osr_i,
  input  logic [1:0]          dwidth_i,
  input  logic                rjust_i,
  input  logic                lsb_first_i,
  input  logic [1:0]          route_i,
  input  logic [ATT_W-1:0]    att_l_i,
  input  logic [ATT_W-1:0]    att_r_i,
  input  logic                mute_i,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sdo_o,
  output logic                underrun_o
);
  import pcm_fmt_pkg::*;

  localparam int FRAME_W = 2 * SLOT_W;
  localparam int BIT_W   = $clog2(FRAME_W);

  logic                      adv, load;
  logic [SAMPLE_W-1:0]       pair_l_q, pair_r_q, sel_l, sel_r;
  logic [1:0][SAMPLE_W-1:0]  scaled;
  logic [FRAME_W-1:0]        frame_next, shreg_q;
  slot_cfg_t                 cfg;
  logic                      sdo_q, underrun_q;

  pcm_fmt_timing #(.TICK_W(TICK_W), .BIT_W(BIT_W)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slot32_i (slot32_i),
    .osr_i    (osr_i),
    .bclk_o   (bclk_o),
    .ws_o     (ws_o),
    .adv_o    (adv),
    .load_o   (load)
  );

  // fresh pair if offered, otherwise repeat the last one
  assign sel_l = valid_i ? left_i  : pair_l_q;
  assign sel_r = valid_i ? right_i : pair_r_q;

  pcm_fmt_gain #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W),
    .ATT_W    (ATT_W),
    .MAX_ATT  (MAX_ATT)
  ) u_gain (
    .left_i  (sel_l),
    .right_i (sel_r),
    .route_i (route_i),
    .att_l_i (att_l_i),
    .att_r_i (att_r_i),
    .out_o   (scaled)
  );

  assign cfg = '{slot32: slot32_i, dwidth: dwidth_i, rjust: rjust_i,
                 lsb_first: lsb_first_i};

  pcm_fmt_slot #(.SAMPLE_W(SAMPLE_W)) u_slot (
    .sample_i (scaled),
    .cfg_i    (cfg),
    .frame_o  (frame_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_l_q   <= '0;
      pair_r_q   <= '0;
      shreg_q    <= '0;
      sdo_q      <= 1'b0;
      underrun_q <= 1'b0;
    end else if (load) begin
      shreg_q    <= frame_next >> 1;
      sdo_q      <= ~mute_i & frame_next[0];
      underrun_q <= ~valid_i;
      if (valid_i) begin
        pair_l_q <= left_i;
        pair_r_q <= right_i;
      end
    end else if (adv) begin
      shreg_q <= shreg_q >> 1;
      sdo_q   <= ~mute_i & shreg_q[0];
    end
  end

  assign ready_o    = load;
  assign sdo_o      = sdo_q;
  assign underrun_o = underrun_q;

endmodule

// File: rtl/pcm_out_fmt_chk.sv
`timescale 1ns/1ps
module pcm_out_fmt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic mute_i,
  input logic bclk_o,
  input logic ws_o,
  input logic sdo_o,
  input logic underrun_o
);

  // R1
  bclk_high_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |=> bclk_o);

  // R2
  ws_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(bclk_o));

  // R2
  sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $fell(bclk_o));

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o && !bclk_o && !ws_o);

  // R9
  underrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !valid_i |=> underrun_o);

  // R9
  underrun_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && valid_i |=> !underrun_o);

  // R9
  underrun_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(underrun_o));

  // R10
  mute_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bclk_o) && $past(mute_i) |-> !sdo_o);

endmodule

bind pcm_out_fmt pcm_out_fmt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .mute_i     (mute_i),
  .bclk_o     (bclk_o),
  .ws_o       (ws_o),
  .sdo_o      (sdo_o),
  .underrun_o (underrun_o)
);

// File: tb/pcm_out_fmt_bench.sv
`timescale 1ns/1ps
module pcm_out_fmt_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [23:0] left = '0, right = '0;
  logic        slot32 = 1'b1;
  logic [1:0]  osr = 2'd0, dw = 2'd3, route = 2'd0;
  logic        rj = 1'b0, lsb = 1'b0, mute = 1'b0;
  logic [7:0]  att_l = '0, att_r = '0;
  logic        bclk, ws, sdo, underrun;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [23:0] pl = '0, pr = '0;

  typedef struct {
    int          nbits;
    logic [63:0] tx;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  int   len_q[$];

  always #2.5 clk = ~clk;

  pcm_out_fmt u_pcm_out_fmt (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .ready_o(ready),
    .left_i(left), .right_i(right), .slot32_i(slot32), .osr_i(osr),
    .dwidth_i(dw), .rjust_i(rj), .lsb_first_i(lsb), .route_i(route),
    .att_l_i(att_l), .att_r_i(att_r), .mute_i(mute),
    .bclk_o(bclk), .ws_o(ws), .sdo_o(sdo), .underrun_o(underrun)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // R7: gain = round(32768*10^(-n/20)), n clamped to 96, floor after product
  function automatic logic [23:0] attn(logic [23:0] s, int a);
    int n;
    longint g, p;
    n = (a > 96) ? 96 : a;
    g = longint'($rtoi(32768.0 * (10.0 ** ((0.0 - n) / 20.0)) + 0.5));
    p = longint'($signed(s)) * g;
    p = p >>> 15;
    return p[23:0];
  endfunction

  // R4 R5 slot contents
  function automatic logic [31:0] slotv(logic [23:0] s);
    int w;
    w = (dw == 2'd3) ? 24 : 16 + 2 * int'(dw);
    if (!slot32) return {16'h0, s[23:8]};
    if (rj) return {8'h0, s} >> (24 - w);
    return {s, 8'h0} & ~(32'hFFFF_FFFF >> w);
  endfunction

  function automatic exp_t build(logic [23:0] l, logic [23:0] r, string req);
    exp_t e;
    logic [23:0] ol, orr;
    logic [31:0] vl, vr;
    int sw;
    sw = slot32 ? 32 : 16;
    ol  = (route == 2'd0 || route == 2'd1) ? l : r;  // R6
    orr = (route == 2'd0 || route == 2'd2) ? r : l;
    vl = slotv(attn(ol, int'(att_l)));
    vr = slotv(attn(orr, int'(att_r)));
    e.nbits = 2 * sw;
    e.tx = '0;
    e.req = req;
    for (int k = 0; k < sw; k++) begin
      e.tx[k]      = lsb ? vl[k] : vl[sw-1-k];  // R3
      e.tx[sw + k] = lsb ? vr[k] : vr[sw-1-k];
    end
    if (mute) e.tx = '0;
    return e;
  endfunction

  task automatic xfer(bit v, logic [23:0] l, logic [23:0] r, bit m, string req);
    do @(negedge clk); while (!ready);
    valid = v; left = l; right = r; mute = m;
    if (v) begin pl = l; pr = r; end
    exp_q.push_back(build(pl, pr, req));
    len_q.push_back(osr == 2'd1 ? 384 : (osr == 2'd2 ? 512 : 256));
    @(posedge clk);
    #1;
    chk(!ready, "R8", "ready one cycle", ready, 0);
    chk(!bclk && !ws, "R2", "frame start clocks", {bclk, ws}, 0);
    chk(underrun == !v, "R9", "underrun flag", underrun, !v);
  endtask

  // monitor: collect bits on bit clock rise, compare whole frames
  initial begin : mon
    logic [63:0] got;
    int n, last_rdy;
    bit inr, bprev, seen;
    got = '0; n = 0; inr = 0; bprev = 0; seen = 0; last_rdy = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_ni) continue;
      if (ready) begin
        if (seen && len_q.size() > 0) begin
          int e;
          e = len_q.pop_front();
          chk(cyc - last_rdy == e, "R1", "frame length", cyc - last_rdy, e);
        end
        seen = 1;
        last_rdy = cyc;
      end
      if (bclk && !bprev) begin
        if (!ws && inr) begin
          if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(n == e.nbits && got == e.tx, e.req, "frame bits", got, e.tx);
          end
          got = '0; n = 0; inr = 0;
        end
        if (n < 64) got[n] = sdo;
        n++;
        inr = ws;
      end
      bprev = bclk;
    end
  end

  initial begin : wdog
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : drv
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({bclk, ws, sdo, ready, underrun} == 5'b0, "R11", "reset outputs",
        {bclk, ws, sdo, ready, underrun}, 0);
    exp_q.push_back('{nbits: 64, tx: 64'h0, req: "R11"});
    rst_ni = 1'b1;

    xfer(1, 24'h123456, 24'hF54322, 0, "R5");
    xfer(1, 24'hFFFFFF, 24'h000001, 0, "R3");
    dw = 2'd1; xfer(1, 24'h89ABCD, 24'h7F00FF, 0, "R5");
    dw = 2'd2; rj = 1; xfer(1, 24'hC0FFEE, 24'h13579B, 0, "R5");
    dw = 2'd0; xfer(1, 24'hA5A5A5, 24'h5A5A5A, 0, "R5");
    dw = 2'd3; xfer(1, 24'h2468AC, 24'h876543, 0, "R5");
    lsb = 1; xfer(1, 24'h0F1E2D, 24'hE1D2C3, 0, "R3");
    lsb = 0; rj = 0;
    slot32 = 0; xfer(1, 24'h345678, 24'hCBA987, 0, "R4");
    lsb = 1; dw = 2'd1; rj = 1; xfer(1, 24'h112233, 24'hEEDDCC, 0, "R4");
    lsb = 0; dw = 2'd3; rj = 0;
    osr = 2'd1; xfer(1, 24'h400000, 24'hC00000, 0, "R1");
    slot32 = 1; xfer(1, 24'h0000FF, 24'hFFFF00, 0, "R1");
    osr = 2'd2; xfer(1, 24'h7FFFFF, 24'h800000, 0, "R1");
    slot32 = 0; xfer(1, 24'h555555, 24'hAAAAAA, 0, "R1");
    osr = 2'd3; slot32 = 1; xfer(1, 24'h3C3C3C, 24'hC3C3C3, 0, "R1");
    osr = 2'd0;
    route = 2'd1; xfer(1, 24'h111111, 24'h222222, 0, "R6");
    route = 2'd2; xfer(1, 24'h333333, 24'h444444, 0, "R6");
    route = 2'd3; xfer(1, 24'h555AAA, 24'h666BBB, 0, "R6");
    route = 2'd0;
    att_l = 8'd1; att_r = 8'd6; xfer(1, 24'h7FFFFF, 24'h812345, 0, "R7");
    att_l = 8'd96; att_r = 8'd200; xfer(1, 24'h7FFFFF, 24'h800000, 0, "R7");
    att_l = 8'd20; att_r = 8'd97; xfer(1, 24'hF00001, 24'h7FFFFF, 0, "R7");
    att_l = 8'd0; att_r = 8'd0;
    xfer(1, 24'h1A2B3C, 24'hD4E5F6, 0, "R8");
    xfer(0, 24'h000000, 24'h000000, 0, "R9");
    route = 2'd3; xfer(0, 24'hFFFFFF, 24'hFFFFFF, 0, "R9");
    route = 2'd0; xfer(1, 24'h6789AB, 24'h98765F, 0, "R9");
    xfer(1, 24'h7FFFFF, 24'hFFFFFF, 1, "R10");
    xfer(1, 24'h123123, 24'h321321, 0, "R10");

    do @(negedge clk); while (!ready);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "frames all seen", exp_q.size(), 0);
    chk(len_q.size() == 0, "R1", "lengths all seen", len_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule